// File: doc/BRIEF.md
# Quiz Buzzer First-Press Lockout

This block decides who answered first in a quiz with eight contestants. Each contestant has one button and one indicator LED. The host controls the round with two inputs. `arm` opens a round. `clear` drops the held result and closes the round. A synchronous reset brings the whole block back to idle.

While a round is open, the first new button press wins. The winner's number, 1 to 8, is frozen on a binary output for a display driver, together with a valid flag. Only the winner's LED lights. Every later press and every further arm request is ignored until the host clears.

The button inputs are assumed to be synchronized and debounced already. A press counts on its rising edge. A button that is held down from before the round opened does not count until it has been released and pressed again.

Top module: `quiz_lockout`

## Requirements
- R1: After a cycle with `rst` high, `winner_valid` is 0, `winner_id` is 0, all `led` bits are 0 and `armed` is 0.
- R2: While `armed` is 0 and no winner is held, button presses are ignored: `winner_valid`, `winner_id` and `led` stay at 0.
- R3: A cycle with `arm` high, while no winner is held and neither `rst` nor `clear` is high, sets `armed` to 1 after that clock edge.
- R4: While `armed` is 1, a rising edge on `btn[i]` (bit i is contestant i+1) has the following effect after that clock edge: `winner_valid` goes to 1, `winner_id` becomes i+1 as a 4-bit binary value, and only `led[i]` is 1.
- R5: If several buttons rise in the same capturing cycle, the lowest contestant number wins.
- R6: Once a winner is held, presses from any contestant leave `winner_id` and `led` unchanged, and `armed` reads 0.
- R7: A held winner stays unchanged until `clear` or `rst`, and `arm` has no effect while a winner is held.
- R8: A cycle with `clear` high sets `winner_valid`, `winner_id`, `led` and `armed` to 0. When `arm` is high in the same cycle, `clear` wins.
- R9: A button that is already high when the round opens is not captured until it goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Host request to open a round |
| clear | input | 1 | Host request to drop the result and close the round |
| btn | input | 8 | Contestant buttons; bit i is contestant i+1 |
| led | output | 8 | Contestant LEDs; only the winner's bit is lit |
| winner_id | output | 4 | Latched winner number 1..8; 0 when none |
| winner_valid | output | 1 | A winner is held |
| armed | output | 1 | The round is open and waiting for a press |

## Verification
Directed cases come first:
- a press while the round is closed, which separates an ungated capture from a gated one;
- a single press, which shows the index-to-number mapping;
- two buttons rising together, which exposes the priority order;
- presses and arm requests after a capture, which show whether the lockout holds;
- `clear` and `arm` in the same cycle, which shows which of the two wins;
- a button held down across arming, which separates edge-based capture from level-based capture.

Random button, arm, clear and reset traffic then runs for thousands of cycles. An independent model computes the expected outputs, so orderings that no directed case reaches are also covered.

// File: rtl/quiz_lockout.sv
module quiz_lockout #(
  parameter int N_PLAYERS = 8,
  localparam int ID_W = $clog2(N_PLAYERS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 arm,
  input  logic                 clear,
  input  logic [N_PLAYERS-1:0] btn,
  output logic [N_PLAYERS-1:0] led,
  output logic [ID_W-1:0]      winner_id,
  output logic                 winner_valid,
  output logic                 armed
);

  logic [N_PLAYERS-1:0] btn_q;
  logic [N_PLAYERS-1:0] rise;
  logic [N_PLAYERS-1:0] first_hot;
  logic [ID_W-1:0]      first_id;
  logic                 take;

  assign rise = btn & ~btn_q;
  assign take = armed & ~winner_valid & (|rise);

  always_comb begin
    first_id  = '0;
    first_hot = '0;
    for (int i = N_PLAYERS - 1; i >= 0; i--) begin
      if (rise[i]) begin
        first_id     = ID_W'(i + 1);
        first_hot    = '0;
        first_hot[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    btn_q <= btn;
    if (rst || clear) begin
      armed        <= 1'b0;
      winner_valid <= 1'b0;
      winner_id    <= '0;
      led          <= '0;
    end else if (!winner_valid) begin
      if (take) begin
        winner_valid <= 1'b1;
        winner_id    <= first_id;
        led          <= first_hot;
        armed        <= 1'b0;
      end else if (arm) begin
        armed <= 1'b1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !winner_valid && !armed && led == '0 && winner_id == '0); // R1
  AST_NO_CAPTURE_CLOSED: assert property (@(posedge clk) disable iff (rst) (!armed && !winner_valid) |=> !winner_valid); // R2
  AST_ONE_LED: assert property (@(posedge clk) disable iff (rst) $onehot0(led) && (winner_valid == (|led))); // R4
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (rst) winner_valid |-> (winner_id != '0 && winner_id <= ID_W'(N_PLAYERS))); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) (winner_valid && !clear) |=> winner_valid && $stable(winner_id) && $stable(led) && !armed); // R7
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst) clear |=> !winner_valid && !armed && led == '0); // R8

endmodule

// File: tb/sim_quiz_lockout.sv
module sim_quiz_lockout;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst, arm, clear;
  logic [N-1:0] btn;
  logic [N-1:0] led;
  logic [3:0]   winner_id;
  logic         winner_valid, armed;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_prev = '0;
  logic         m_armed = 1'b0;
  logic         m_valid = 1'b0;
  logic [3:0]   m_id = '0;

  always #5 clk = ~clk;

  quiz_lockout u0 (
    .clk(clk), .rst(rst), .arm(arm), .clear(clear), .btn(btn),
    .led(led), .winner_id(winner_id), .winner_valid(winner_valid), .armed(armed)
  );

  function automatic logic [3:0] lowest(input logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (e[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  function automatic logic [N-1:0] exp_led(input logic v, input logic [3:0] id);
    logic [N-1:0] r = '0;
    if (v) r[id - 1] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic c, input logic [N-1:0] b, input string req);
    logic [N-1:0] e;
    @(negedge clk);
    rst = r; arm = a; clear = c; btn = b;
    @(posedge clk);
    e = b & ~m_prev;
    if (r || c) begin
      m_armed = 0; m_valid = 0; m_id = 0;
    end else if (!m_valid) begin
      if (m_armed && e != '0) begin
        m_valid = 1; m_id = lowest(e); m_armed = 0;
      end else if (a) m_armed = 1;
    end
    m_prev = b;
    #1;
    check(req, "winner_valid", int'(winner_valid), int'(m_valid));
    check(req, "winner_id", int'(winner_id), int'(m_id));
    check(req, "led", int'(led), int'(exp_led(m_valid, m_id)));
    check(req, "armed", int'(armed), int'(m_armed));
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd7;
    logic [N-1:0] rb;
    rst = 1; arm = 0; clear = 0; btn = '0;
    step(1, 0, 0, '0, "R1");
    step(1, 0, 0, '0, "R1");
    step(0, 0, 0, 8'h04, "R2");
    step(0, 0, 0, 8'h00, "R2");
    step(0, 1, 0, 8'h00, "R3");
    step(0, 0, 0, 8'h10, "R4");
    step(0, 0, 0, 8'h11, "R6");
    step(0, 1, 0, 8'h00, "R7");
    step(0, 0, 0, 8'h80, "R7");
    step(0, 1, 1, 8'h00, "R8");
    step(0, 0, 0, 8'h00, "R8");
    step(0, 0, 0, 8'h02, "R9");
    step(0, 1, 0, 8'h02, "R9");
    step(0, 0, 0, 8'h02, "R9");
    step(0, 0, 0, 8'h00, "R9");
    step(0, 0, 0, 8'h02, "R9");
    step(0, 0, 1, 8'h00, "R8");
    step(0, 1, 0, 8'h00, "R3");
    step(0, 0, 0, 8'h48, "R5");
    step(0, 0, 0, 8'h00, "R7");
    step(1, 0, 0, 8'h00, "R1");
    void'($urandom(seed));
    for (int k = 0; k < 4000; k++) begin
      rb = '0;
      for (int j = 0; j < N; j++) if ($urandom_range(0, 9) == 0) rb[j] = 1'b1;
      step($urandom_range(0, 199) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 24) == 0, rb, "R4");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule